// File: doc/BRIEF.md
# Programmable per-line edge detector

The block watches a wide bundle of trace input lines and reports, on every line separately, the transitions that software has asked for. Each line carries a two-bit edge-kind field choosing rising, falling or both transitions (one code is reserved and reports nothing), and a one-bit suppress flag that silences the line. The fields sit in a bank of 32-bit kind registers (16 fields per word) and the flags in a bank of 32-bit suppress registers (32 flags per word), reached through a simple word-aligned register port with combinational read data.

Inputs pass through a sampling register, and a previous-sample register sits behind it. A line's pulse output goes high for one cycle when the two samples differ in the selected direction. A single event output, registered one cycle after the per-line pulses, reports that any line fired. A global detect-enable input silences all reporting. Because the previous-sample register keeps following the inputs while detection is off, turning detection on never produces a false edge.

Top module: `line_edge_detector`

## Requirements
- R1: After reset all kind and suppress registers read 0, and `edge_pulse_o` and `event_o` are 0.
- R2: Kind register n (n = 0..15) lives at byte address 0x808 + 4*n. A write stores `reg_wdata_i`, and a read returns it on `reg_rdata_o` in the same cycle. Line i uses register i/16, bits 2*(i mod 16)+1 down to 2*(i mod 16).
- R3: Suppress register n (n = 0..7) lives at byte address 0x848 + 4*n, with read and write as in R2. Line i uses register i/32, bit i mod 32.
- R4: An address outside both banks, or one not a multiple of 4, reads as 0, and a write to it changes no register.
- R5: Kind code 00 (rising) is timed from the input change. A 0-to-1 change on a line, set up before clock edge k, drives that line's pulse high for exactly the cycle after edge k+1.
- R6: Kind code 01 (falling) pulses, with the same timing as R5, on a 1-to-0 change only.
- R7: Kind code 10 (both) pulses, with the same timing as R5, on any change. Under every code, a line that did not change does not pulse.
- R8: A line whose kind code is 11 never pulses.
- R9: A line whose suppress bit is 1 never pulses.
- R10: `event_o` in a cycle equals the OR of `edge_pulse_o` in the cycle before.
- R11: While `det_en_i` is 0 no line pulses. An input change made while it is 0 gives no pulse after it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en_i | input | 1 | Global detect enable |
| lines_i | input | 256 | Trace input lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| edge_pulse_o | output | 256 | Per-line edge pulses |
| event_o | output | 1 | Any-line event, one cycle after the pulses |

## Verification
The situation hardest to bring about from the ports is a mix of lines with different kinds and suppress flags under one input pattern. Each line needs its own field inside a packed word, and every field change is a read-modify-write through the port. The bench keeps an image of both banks and fills them with random words, so that every kind code and suppress value appears on many lines at once while random patterns drive the inputs. The disabled-then-re-enabled case is reached by changing the inputs with the enable low, then holding them and raising the enable, which exercises the previous-sample tracking.

// File: rtl/led_pkg.sv
package led_pkg;

   typedef enum logic [1:0] {
      EK_RISE = 2'b00,
      EK_FALL = 2'b01,
      EK_BOTH = 2'b10,
      EK_NONE = 2'b11
   } edge_kind_e;

   // Classify one line from its current and previous sample.
   function automatic logic edge_hit(input logic cur, input logic prev,
                                     input logic [1:0] kind);
      logic hit;
      case (edge_kind_e'(kind))
         EK_RISE: hit = cur & ~prev;
         EK_FALL: hit = ~cur & prev;
         EK_BOTH: hit = cur ^ prev;
         default: hit = 1'b0;
      endcase
      return hit;
   endfunction

endpackage

// File: rtl/led_regbank.sv
module led_regbank #(
   parameter int NUM_LINES = 256,
   parameter int REG_W     = 32,
   parameter int ADDR_W    = 12,
   parameter int KIND_BASE = 'h808,
   parameter int SUPP_BASE = 'h848
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_i,
   input  logic [ADDR_W-1:0]      addr_i,
   input  logic [REG_W-1:0]       wdata_i,
   output logic [REG_W-1:0]       rdata_o,
   output logic [2*NUM_LINES-1:0] kind_flat_o,
   output logic [NUM_LINES-1:0]   supp_flat_o
);
   localparam int BYTES     = REG_W / 8;
   localparam int ALIGN_W   = $clog2(BYTES);
   localparam int KIND_REGS = (2 * NUM_LINES) / REG_W;
   localparam int SUPP_REGS = NUM_LINES / REG_W;
   localparam int KIDX_W    = (KIND_REGS > 1) ? $clog2(KIND_REGS) : 1;
   localparam int SIDX_W    = (SUPP_REGS > 1) ? $clog2(SUPP_REGS) : 1;
   localparam logic [ADDR_W-1:0] KIND_SPAN = ADDR_W'(KIND_REGS * BYTES);
   localparam logic [ADDR_W-1:0] SUPP_SPAN = ADDR_W'(SUPP_REGS * BYTES);

   if (KIND_BASE + KIND_REGS * BYTES > (1 << ADDR_W)) begin : g_chk_kind_fit
      $error("kind bank does not fit in the address space");
   end
   if (SUPP_BASE + SUPP_REGS * BYTES > (1 << ADDR_W)) begin : g_chk_supp_fit
      $error("suppress bank does not fit in the address space");
   end

   logic [ADDR_W-1:0] kind_off, supp_off;
   logic              aligned, kind_hit, supp_hit;
   logic [KIDX_W-1:0] kind_idx;
   logic [SIDX_W-1:0] supp_idx;

   assign aligned  = (addr_i[ALIGN_W-1:0] == '0);
   assign kind_off = addr_i - ADDR_W'(KIND_BASE);
   assign supp_off = addr_i - ADDR_W'(SUPP_BASE);
   assign kind_hit = aligned && (kind_off < KIND_SPAN);
   assign supp_hit = aligned && (supp_off < SUPP_SPAN);
   assign kind_idx = kind_off[ALIGN_W +: KIDX_W];
   assign supp_idx = supp_off[ALIGN_W +: SIDX_W];

   for (genvar g = 0; g < KIND_REGS; g++) begin : g_kind
      logic [REG_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr_i && kind_hit && kind_idx == KIDX_W'(g))
            word_q <= wdata_i;
      end
      assign kind_flat_o[g*REG_W +: REG_W] = word_q;
   end

   for (genvar g = 0; g < SUPP_REGS; g++) begin : g_supp
      logic [REG_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (wr_i && supp_hit && supp_idx == SIDX_W'(g))
            word_q <= wdata_i;
      end
      assign supp_flat_o[g*REG_W +: REG_W] = word_q;
   end

   always_comb begin
      rdata_o = '0;
      if (kind_hit)
         rdata_o = kind_flat_o[kind_idx*REG_W +: REG_W];
      else if (supp_hit)
         rdata_o = supp_flat_o[supp_idx*REG_W +: REG_W];
   end

   // R4: a write that decodes to neither bank leaves every register as it was
   a_r4_stray_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_i && !kind_hit && !supp_hit) |-> ($stable(kind_flat_o) && $stable(supp_flat_o)));

   // R4: undecoded addresses read as zero
   a_r4_stray_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!kind_hit && !supp_hit) |-> (rdata_o == '0));

endmodule

// File: rtl/led_line_cell.sv
module led_line_cell
   import led_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       cur_i,
   input  logic       prev_i,
   input  logic [1:0] kind_i,
   input  logic       supp_i,
   output logic       pulse_o
);
   logic hit;

   assign hit = en_i && !supp_i && edge_hit(cur_i, prev_i, kind_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_o <= 1'b0;
      else        pulse_o <= hit;
   end

   // R8: reserved kind code never reports
   a_r8_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(kind_i) == EK_NONE) |-> !pulse_o);

   // R9: a suppressed line never reports
   a_r9_suppressed_silent: assert property (@(posedge clk) disable iff (!rst_n)
      $past(supp_i) |-> !pulse_o);

   // R7: no change between samples gives no pulse under any code
   a_r7_no_change_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cur_i == prev_i) |-> !pulse_o);

endmodule

// File: rtl/led_event_reduce.sv
module led_event_reduce #(
   parameter int NUM_LINES = 256
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pulses_i,
   output logic                 event_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) event_o <= 1'b0;
      else        event_o <= |pulses_i;
   end

   // R10: event follows the OR of last cycle's pulses
   a_r10_event_follows: assert property (@(posedge clk) disable iff (!rst_n)
      event_o == $past(|pulses_i));

endmodule

// File: rtl/line_edge_detector.sv
module line_edge_detector #(
   parameter int NUM_LINES = 256,
   parameter int REG_W     = 32,
   parameter int ADDR_W    = 12,
   parameter int KIND_BASE = 'h808,
   parameter int SUPP_BASE = 'h848
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 det_en_i,
   input  logic [NUM_LINES-1:0] lines_i,
   input  logic                 reg_wr_i,
   input  logic [ADDR_W-1:0]    reg_addr_i,
   input  logic [REG_W-1:0]     reg_wdata_i,
   output logic [REG_W-1:0]     reg_rdata_o,
   output logic [NUM_LINES-1:0] edge_pulse_o,
   output logic                 event_o
);
   if (REG_W < 8 || (REG_W & (REG_W - 1)) != 0) begin : g_chk_regw
      $error("REG_W must be a power of two of at least 8");
   end
   if (NUM_LINES < REG_W || NUM_LINES % REG_W != 0) begin : g_chk_lines
      $error("NUM_LINES must be a positive multiple of REG_W");
   end

   logic [2*NUM_LINES-1:0] kind_flat;
   logic [NUM_LINES-1:0]   supp_flat;
   logic [NUM_LINES-1:0]   sample_q, prev_q;

   led_regbank #(
      .NUM_LINES(NUM_LINES), .REG_W(REG_W), .ADDR_W(ADDR_W),
      .KIND_BASE(KIND_BASE), .SUPP_BASE(SUPP_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
      .rdata_o(reg_rdata_o),
      .kind_flat_o(kind_flat), .supp_flat_o(supp_flat)
   );

   // The previous sample keeps following the inputs whatever the enable.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_q <= '0;
         prev_q   <= '0;
      end else begin
         sample_q <= lines_i;
         prev_q   <= sample_q;
      end
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      led_line_cell u_cell (
         .clk(clk), .rst_n(rst_n), .en_i(det_en_i),
         .cur_i(sample_q[i]), .prev_i(prev_q[i]),
         .kind_i(kind_flat[2*i +: 2]), .supp_i(supp_flat[i]),
         .pulse_o(edge_pulse_o[i])
      );
   end

   led_event_reduce #(.NUM_LINES(NUM_LINES)) u_event (
      .clk(clk), .rst_n(rst_n), .pulses_i(edge_pulse_o), .event_o(event_o)
   );

   // R11: nothing reports in the cycle after detection was off
   a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(det_en_i) |-> (edge_pulse_o == '0));

   // R9: no suppressed line shows a pulse
   a_r9_supp_vector: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_pulse_o & $past(supp_flat)) == '0);

endmodule

// File: tb/sim_line_edge_detector.sv
`timescale 1ns/1ps
module sim_line_edge_detector;
   localparam int N = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          det_en = 1'b0;
   logic [N-1:0]  lines = '0;
   logic          reg_wr = 1'b0;
   logic [11:0]   reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [N-1:0]  pulse;
   logic          evt;

   always #4 clk = ~clk;

   line_edge_detector u0 (
      .clk(clk), .rst_n(rst_n), .det_en_i(det_en), .lines_i(lines),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
      .reg_rdata_o(reg_rdata), .edge_pulse_o(pulse), .event_o(evt)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 0;
   bit    cmp_on  = 0;
   string cur_req = "R1";

   // Behavioural reference: register image plus two sample stages.
   logic [31:0]  m_kind [16];
   logic [31:0]  m_supp [8];
   logic [N-1:0] m_sample, m_prev, m_pulse;
   logic         m_event;

   function automatic logic ref_hit(logic cur, logic prv, int code);
      if (code == 0) return cur && !prv;
      if (code == 1) return !cur && prv;
      if (code == 2) return cur != prv;
      return 1'b0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 16; k++) m_kind[k] = '0;
         for (int k = 0; k < 8; k++)  m_supp[k] = '0;
         m_sample = '0; m_prev = '0; m_pulse = '0; m_event = 0;
      end else begin
         logic [N-1:0] nxt;
         int a;
         for (int i = 0; i < N; i++) begin
            int code;
            code = (m_kind[i/16] >> (2*(i%16))) & 3;
            nxt[i] = det_en && !m_supp[i/32][i%32] && ref_hit(m_sample[i], m_prev[i], code);
         end
         m_event  = |m_pulse;
         m_pulse  = nxt;
         m_prev   = m_sample;
         m_sample = lines;
         a = int'(reg_addr);
         if (reg_wr && a % 4 == 0) begin
            if (a >= 'h808 && a < 'h848) m_kind[(a-'h808)/4] = reg_wdata;
            else if (a >= 'h848 && a < 'h868) m_supp[(a-'h848)/4] = reg_wdata;
         end
      end
   end

   function automatic logic [31:0] ref_read(int a);
      if (a % 4 != 0) return '0;
      if (a >= 'h808 && a < 'h848) return m_kind[(a-'h808)/4];
      if (a >= 'h848 && a < 'h868) return m_supp[(a-'h848)/4];
      return '0;
   endfunction

   task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Per-clock comparison against the reference model.
   always @(negedge clk) begin
      if (rst_n && cmp_on && !done) begin
         check({cur_req, " pulse"}, pulse, m_pulse);
         check({cur_req, " event(R10)"}, N'(evt), N'(m_event));
      end
   end

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = 12'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic rd(string req, int a);
      @(negedge clk);
      reg_addr = 12'(a);
      #1;
      check(req, N'(reg_rdata), N'(ref_read(a)));
   endtask

   task automatic fill_kind(logic [31:0] v);
      for (int k = 0; k < 16; k++) wr('h808 + 4*k, v);
   endtask

   task automatic fill_supp(logic [31:0] v);
      for (int k = 0; k < 8; k++) wr('h848 + 4*k, v);
   endtask

   function automatic logic [N-1:0] rnd();
      logic [N-1:0] r;
      for (int k = 0; k < N/32; k++) r[k*32 +: 32] = $urandom;
      return r;
   endfunction

   task automatic run_random(int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         lines = rnd();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 pulse", pulse, '0);
      check("R1 event", N'(evt), '0);
      rd("R1 kind0", 'h808);
      rd("R1 supp7", 'h864);
      rst_n = 1;
      cmp_on = 1;

      // R2 / R3: mapping and readback
      cur_req = "R2";
      for (int k = 0; k < 16; k++) wr('h808 + 4*k, 32'h1357_0000 + k);
      for (int k = 0; k < 16; k++) rd("R2 readback", 'h808 + 4*k);
      cur_req = "R3";
      for (int k = 0; k < 8; k++) wr('h848 + 4*k, 32'hA5A5_0000 + k);
      for (int k = 0; k < 8; k++) rd("R3 readback", 'h848 + 4*k);

      // R4: stray and misaligned accesses
      cur_req = "R4";
      wr('h804, 32'hFFFF_FFFF);
      wr('h868, 32'hFFFF_FFFF);
      wr('h809, 32'hFFFF_FFFF);
      wr('h84A, 32'hFFFF_FFFF);
      rd("R4 stray read", 'h804);
      rd("R4 stray read", 'h868);
      rd("R4 misaligned read", 'h80A);
      rd("R4 kind0 unchanged", 'h808);
      rd("R4 kind15 unchanged", 'h844);
      rd("R4 supp0 unchanged", 'h848);

      // R5: rising, directed timing on line 5
      cur_req = "R5";
      fill_kind('0);
      fill_supp('0);
      @(negedge clk); det_en = 1; lines = '0;
      repeat (3) @(negedge clk);
      lines[5] = 1;            // before edge k
      @(negedge clk);          // after edge k: still quiet
      check("R5 before", pulse, '0);
      @(negedge clk);          // after edge k+1
      check("R5 pulse line5", pulse, N'(1) << 5);
      @(negedge clk);
      check("R5 single cycle", pulse, '0);
      check("R10 event", N'(evt), N'(1));
      lines[5] = 0;
      repeat (2) @(negedge clk);
      check("R5 fall ignored", pulse, '0);
      run_random(30);

      cur_req = "R6";
      fill_kind(32'h5555_5555);
      run_random(30);
      cur_req = "R7";
      fill_kind(32'hAAAA_AAAA);
      run_random(30);
      cur_req = "R8";
      fill_kind(32'hFFFF_FFFF);
      run_random(20);
      check("R8 reserved quiet", pulse, '0);

      // R9 / R10: mixed kinds and suppress flags
      cur_req = "R9";
      fill_supp(32'hFFFF_FFFF);
      fill_kind(32'hAAAA_AAAA);
      run_random(10);
      check("R9 all suppressed", pulse, '0);
      for (int pass = 0; pass < 4; pass++) begin
         for (int k = 0; k < 16; k++) wr('h808 + 4*k, $urandom);
         for (int k = 0; k < 8; k++) wr('h848 + 4*k, $urandom);
         cur_req = "R9/R10 mixed";
         run_random(40);
      end

      // R11: enable low, then re-enable with no false edge
      cur_req = "R11";
      fill_supp('0);
      fill_kind('0);
      @(negedge clk); det_en = 0;
      run_random(10);
      @(negedge clk); lines = '1;
      @(negedge clk);
      check("R11 disabled quiet", pulse, '0);
      repeat (3) @(negedge clk);
      det_en = 1;
      repeat (3) @(negedge clk);
      check("R11 no false edge", pulse, '0);
      check("R11 no false event", N'(evt), '0);
      run_random(20);

      @(negedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule